// File: doc/BRIEF.md
# DRAM Address Map Selector

This block picks the address-mapping configuration index that a DRAM scheduler should use once the memory geometry is known. It takes the detected column and row address widths, a flag that marks a 16-bit data bus, and a requested mapping scheme. A start pulse launches a search over a fixed table of sixteen candidate configurations. The search tests one entry per clock, in ascending index order, against a rule chosen by the scheme. The first entry that satisfies the rule is written into the configuration register and reported with a one-cycle done pulse.

If no entry satisfies the rule, the block still pulses done, but it also raises an error flag and leaves the configuration register untouched. A scheme code with no defined rule is rejected on the clock that accepts the start. The geometry itself comes from elsewhere, for example from a probing routine that runs before this block is started.

Top module: `addr_map_sel`

## Requirements
- R1: After reset, busy_o, done_o and err_o are 0 and cfg_idx_o is 0.
- R2: The effective column count equals col_bits_i when bus_half_i is 0 and col_bits_i minus one when bus_half_i is 1. Only the effective count takes part in matching.
- R3: Scheme code 0 (bank before row) uses entries 0 to 10, with the (rows, columns) pairs 0:(13,10) 1:(14,10) 2:(15,10) 3:(16,10) 4:(14,11) 5:(15,11) 6:(16,11) 7:(13,9) 8:(14,9) 9:(15,9) 10:(16,9). An entry matches only when its rows and its columns both equal the inputs.
- R4: Scheme code 1 (row before bank) uses entries 11:(15,10), 12:(14,11) and 13:(13,10). An entry matches when its columns are equal and its rows do not exceed the detected rows.
- R5: Scheme code 2 (device before row) uses entries 14:(16,10) and 15:(16,9). An entry matches when its columns are equal, or when its columns are at most the detected columns and its rows are equal.
- R6: Entries of other schemes are skipped. The lowest matching index is chosen.
- R7: A match at index k gives a done_o pulse of one cycle, k+1 clocks after the edge that accepts start_i. busy_o is high from that edge until done_o rises.
- R8: When no entry matches, done_o and err_o rise together 16 clocks after the accepting edge, and cfg_idx_o keeps its previous value.
- R9: Scheme code 3 gives done_o and err_o on the accepting edge itself. busy_o stays 0 and cfg_idx_o is unchanged.
- R10: While busy_o is high, start_i and all other inputs are ignored.
- R11: err_o and cfg_idx_o hold their values between searches. err_o clears when the next search is accepted.
- R12: A start_i that is asserted in the cycle where done_o is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a search when idle |
| col_bits_i | input | 4 | Detected column address bits |
| row_bits_i | input | 5 | Detected row address bits |
| bus_half_i | input | 1 | 1 for a 16-bit data bus, 0 for 32-bit |
| scheme_i | input | 2 | Requested mapping scheme code (0, 1, 2; 3 is undefined) |
| busy_o | output | 1 | A search is in progress |
| done_o | output | 1 | One-cycle pulse when a search ends |
| err_o | output | 1 | The last search found no entry |
| cfg_idx_o | output | 4 | Configuration register holding the chosen index |

## Verification
Two events can fall in the same cycle: a search finishing (done_o high, busy_o low) and a new start request. The bench provokes this by driving start_i with a second geometry on the exact sample where the first done_o is seen. It then requires a second done with the second index at the latency that index implies. The opposite case is also covered: a start arriving mid-search, with different inputs, must leave the first search's latency and result intact.

// File: rtl/addr_map_pkg.sv
package addr_map_pkg;
  parameter int COL_W = 4;
  parameter int ROW_W = 5;
  parameter int IDX_W = 4;

  typedef enum logic [1:0] {
    MAP_BANK_ROW = 2'd0,
    MAP_ROW_BANK = 2'd1,
    MAP_DEV_ROW  = 2'd2,
    MAP_NONE     = 2'd3
  } map_scheme_e;

  typedef struct packed {
    logic [ROW_W-1:0] rows;
    logic [COL_W-1:0] cols;
    map_scheme_e      scheme;
  } map_entry_t;
endpackage

// File: rtl/addr_map_table.sv
module addr_map_table
  import addr_map_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  output map_entry_t       entry_o
);
  function automatic map_entry_t mk(input int r, input int c, input map_scheme_e s);
    map_entry_t e;
    e.rows   = ROW_W'(r);
    e.cols   = COL_W'(c);
    e.scheme = s;
    return e;
  endfunction

  always_comb begin
    case (idx_i)
      4'd0:    entry_o = mk(13, 10, MAP_BANK_ROW);
      4'd1:    entry_o = mk(14, 10, MAP_BANK_ROW);
      4'd2:    entry_o = mk(15, 10, MAP_BANK_ROW);
      4'd3:    entry_o = mk(16, 10, MAP_BANK_ROW);
      4'd4:    entry_o = mk(14, 11, MAP_BANK_ROW);
      4'd5:    entry_o = mk(15, 11, MAP_BANK_ROW);
      4'd6:    entry_o = mk(16, 11, MAP_BANK_ROW);
      4'd7:    entry_o = mk(13, 9,  MAP_BANK_ROW);
      4'd8:    entry_o = mk(14, 9,  MAP_BANK_ROW);
      4'd9:    entry_o = mk(15, 9,  MAP_BANK_ROW);
      4'd10:   entry_o = mk(16, 9,  MAP_BANK_ROW);
      4'd11:   entry_o = mk(15, 10, MAP_ROW_BANK);
      4'd12:   entry_o = mk(14, 11, MAP_ROW_BANK);
      4'd13:   entry_o = mk(13, 10, MAP_ROW_BANK);
      4'd14:   entry_o = mk(16, 10, MAP_DEV_ROW);
      4'd15:   entry_o = mk(16, 9,  MAP_DEV_ROW);
      default: entry_o = mk(0, 0, MAP_NONE);
    endcase
  end
endmodule

// File: rtl/addr_map_rule.sv
module addr_map_rule
  import addr_map_pkg::*;
(
  input  map_entry_t       entry_i,
  input  map_scheme_e      scheme_i,
  input  logic [COL_W-1:0] cols_i,
  input  logic [ROW_W-1:0] rows_i,
  output logic             hit_o
);
  logic col_eq, row_eq, col_le, row_le;

  assign col_eq = (entry_i.cols == cols_i);
  assign row_eq = (entry_i.rows == rows_i);
  assign col_le = (entry_i.cols <= cols_i);
  assign row_le = (entry_i.rows <= rows_i);

  always_comb begin
    hit_o = 1'b0;
    if (entry_i.scheme == scheme_i) begin
      case (scheme_i)
        MAP_BANK_ROW: hit_o = col_eq && row_eq;
        MAP_ROW_BANK: hit_o = col_eq && row_le;
        MAP_DEV_ROW:  hit_o = col_eq || (col_le && row_eq);
        default:      hit_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/addr_map_sel.sv
module addr_map_sel
  import addr_map_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_bits_i,
  input  logic [ROW_W-1:0] row_bits_i,
  input  logic             bus_half_i,
  input  logic [1:0]       scheme_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [IDX_W-1:0] cfg_idx_o
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic             busy_q, done_q, err_q;
  logic [IDX_W-1:0] idx_q, cfg_q;
  logic [COL_W-1:0] cols_q;
  logic [ROW_W-1:0] rows_q;
  map_scheme_e      scheme_q;
  map_entry_t       entry;
  logic             hit;
  logic             accept;
  logic [COL_W-1:0] eff_cols;

  assign accept   = start_i && !busy_q;
  assign eff_cols = col_bits_i - COL_W'(bus_half_i);

  addr_map_table u_table (
    .idx_i   (idx_q),
    .entry_o (entry)
  );

  addr_map_rule u_rule (
    .entry_i  (entry),
    .scheme_i (scheme_q),
    .cols_i   (cols_q),
    .rows_i   (rows_q),
    .hit_o    (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      idx_q    <= '0;
      cfg_q    <= '0;
      cols_q   <= '0;
      rows_q   <= '0;
      scheme_q <= MAP_NONE;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        if (map_scheme_e'(scheme_i) == MAP_NONE) begin
          done_q <= 1'b1;
          err_q  <= 1'b1;
        end else begin
          busy_q   <= 1'b1;
          err_q    <= 1'b0;
          idx_q    <= '0;
          cols_q   <= eff_cols;
          rows_q   <= row_bits_i;
          scheme_q <= map_scheme_e'(scheme_i);
        end
      end else if (busy_q) begin
        if (hit) begin
          cfg_q  <= idx_q;
          done_q <= 1'b1;
          busy_q <= 1'b0;
        end else if (idx_q == LAST_IDX) begin
          done_q <= 1'b1;
          err_q  <= 1'b1;
          busy_q <= 1'b0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign cfg_idx_o = cfg_q;

  // busy cycle counter for the latency bound
  logic [IDX_W:0] busy_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= '0;
    else if (busy_q) busy_cnt <= busy_cnt + 1'b1;
    else             busy_cnt <= '0;
  end

  assert_search_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cnt <= (IDX_W+1)'(ENTRIES));

  assert_busy_ends_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o));

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !done_o);

  assert_not_busy_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && busy_o));

  assert_unknown_scheme_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && scheme_i == 2'd3) |=> (done_o && err_o && !busy_o));

  assert_cfg_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && !err_o) |-> $stable(cfg_idx_o));

  assert_err_with_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> done_o);
endmodule

// File: tb/test_addr_map_sel.sv
module test_addr_map_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] col_bits = '0;
  logic [4:0] row_bits = '0;
  logic       bus_half = 1'b0;
  logic [1:0] scheme = '0;
  logic       busy, done, err;
  logic [3:0] cfg_idx;

  int checks = 0;
  int errors = 0;
  logic [3:0] last_cfg = '0;

  always #5 clk = ~clk;

  addr_map_sel i_addr_map_sel (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .col_bits_i (col_bits),
    .row_bits_i (row_bits),
    .bus_half_i (bus_half),
    .scheme_i   (scheme),
    .busy_o     (busy),
    .done_o     (done),
    .err_o      (err),
    .cfg_idx_o  (cfg_idx)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive_start(input [3:0] c, input [4:0] r, input bit h, input [1:0] s);
    start = 1'b1; col_bits = c; row_bits = r; bus_half = h; scheme = s;
  endtask

  // wait for done; returns latency in negedge samples since start was driven
  task automatic wait_done(output int n, output bit busy_bad, input int exp_lat);
    n = 0; busy_bad = 0;
    while (1) begin
      @(negedge clk);
      n++;
      if (n == 1) start = 1'b0;
      if (done) break;
      if (!busy) busy_bad = 1;
      if (n > 40) break;
    end
    if (exp_lat == 1) busy_bad = busy;
  endtask

  task automatic run(input [3:0] c, input [4:0] r, input bit h, input [1:0] s,
                     input [3:0] exp_idx, input bit exp_err, input string req);
    int n; bit bb; int lat;
    lat = (s == 2'd3) ? 1 : (exp_err ? 17 : exp_idx + 2);
    drive_start(c, r, h, s);
    wait_done(n, bb, lat);
    check(n == lat, req, "done latency", n, lat);
    check(err == exp_err, req, "err", err, exp_err);
    check(!bb, req, "busy during search", bb, 0);
    if (!exp_err) last_cfg = exp_idx;
    check(cfg_idx == last_cfg, req, "cfg index", cfg_idx, last_cfg);
    @(negedge clk);
    check(!done, req, "done single pulse", done, 0);
  endtask

  task automatic t_reset();
    check(!busy && !done && !err && cfg_idx == 0, "R1", "reset state",
          {busy, done, err, cfg_idx}, 0);
  endtask

  task automatic t_bank_row();
    run(4'd10, 5'd15, 1'b0, 2'd0, 4'd2,  1'b0, "R3");
    run(4'd11, 5'd16, 1'b1, 2'd0, 4'd3,  1'b0, "R2");
    run(4'd9,  5'd16, 1'b0, 2'd0, 4'd10, 1'b0, "R3");
    run(4'd12, 5'd16, 1'b0, 2'd0, 4'd0,  1'b1, "R8");
  endtask

  task automatic t_row_bank();
    run(4'd10, 5'd16, 1'b0, 2'd1, 4'd11, 1'b0, "R4");
    run(4'd10, 5'd14, 1'b0, 2'd1, 4'd13, 1'b0, "R6");
    run(4'd11, 5'd13, 1'b0, 2'd1, 4'd0,  1'b1, "R4");
    run(4'd12, 5'd14, 1'b1, 2'd1, 4'd12, 1'b0, "R2");
  endtask

  task automatic t_dev_row();
    run(4'd10, 5'd12, 1'b0, 2'd2, 4'd14, 1'b0, "R5");
    run(4'd11, 5'd16, 1'b0, 2'd2, 4'd14, 1'b0, "R5");
    run(4'd9,  5'd13, 1'b0, 2'd2, 4'd15, 1'b0, "R5");
    run(4'd11, 5'd15, 1'b0, 2'd2, 4'd0,  1'b1, "R5");
  endtask

  task automatic t_unknown();
    run(4'd10, 5'd15, 1'b0, 2'd3, 4'd0, 1'b1, "R9");
  endtask

  task automatic t_hold();
    repeat (5) @(negedge clk);
    check(err == 1'b1 && !done, "R11", "err held idle", err, 1);
    check(cfg_idx == last_cfg, "R11", "cfg held idle", cfg_idx, last_cfg);
    run(4'd10, 5'd13, 1'b0, 2'd0, 4'd0, 1'b0, "R11");
    check(err == 1'b0, "R11", "err cleared by new search", err, 0);
  endtask

  task automatic t_ignore_busy();
    int n; bit bb;
    drive_start(4'd9, 5'd16, 1'b0, 2'd0);
    n = 0; bb = 0;
    while (1) begin
      @(negedge clk);
      n++;
      if (n == 1) start = 1'b0;
      if (n == 3) drive_start(4'd10, 5'd13, 1'b0, 2'd0);
      if (n == 4) start = 1'b0;
      if (done || n > 40) break;
    end
    check(n == 12, "R10", "latency with start while busy", n, 12);
    check(cfg_idx == 4'd10 && !err, "R10", "result with start while busy", cfg_idx, 10);
    last_cfg = 4'd10;
    @(negedge clk);
    check(!busy && !done, "R10", "no second search", {busy, done}, 0);
  endtask

  task automatic t_back_to_back();
    int n; bit bb;
    drive_start(4'd10, 5'd13, 1'b0, 2'd0);
    wait_done(n, bb, 2);
    check(n == 2 && cfg_idx == 4'd0, "R12", "first search", cfg_idx, 0);
    drive_start(4'd11, 5'd14, 1'b0, 2'd0);
    wait_done(n, bb, 6);
    check(n == 6, "R12", "start in done cycle latency", n, 6);
    check(cfg_idx == 4'd4 && !err, "R12", "start in done cycle index", cfg_idx, 4);
    last_cfg = 4'd4;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bank_row();
    t_row_bank();
    t_dev_row();
    t_unknown();
    t_hold();
    t_ignore_busy();
    t_back_to_back();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule